// File: doc/BRIEF.md
# Memory-Mapped Adder Register Block

A small peripheral that sits behind a simple 32-bit register port and answers inside a single 12-bit address segment (segment value 0x321). It keeps two operand registers, a result register and one shared word whose upper half reports status and whose lower half carries control. Software loads both operands, raises the start bit in the control half, polls the status half until the done bit appears, then reads the sum.

The sum is taken one clock after the start bit goes from 0 to 1. It is the 32-bit sum of the operands with any carry out discarded. The result register cannot be written from the port. Software clears the done flag by writing the start bit back to 0. A write to the shared word only changes the control half. Any value written to the status half is dropped.

The port is a plain strobe interface. A write is taken on the rising clock edge while `wr_en` is high. Read data is combinational and is valid while `rd_en` is high. It reads as zero whenever the access does not hit the block.

Top module: `adder_regblock`

## Requirements
- R1: An access hits only when address bits 15:4 equal 0x321 and bits 1:0 are zero. A write that misses changes no register. `rdata` is zero whenever `rd_en` is low or the address misses.
- R2: Register index sits in address bits 3:2. Index 0 is operand A and index 1 is operand B. Each reads back the last full 32-bit value written to it.
- R3: After reset, all four indices read 0x0000_0000.
- R4: Index 3 holds status in bits 31:16 and control in bits 15:0. A write to index 3 stores only control bit 0. Written status bits and control bits 15:1 are ignored and read as zero.
- R5: When control bit 0 is written from 0 to 1, status bit 0 is still 0 on the cycle after the write. One clock later status bit 0 is 1 and index 3 reads 0x0001_0001.
- R6: At that same clock, index 2 loads (A + B) mod 2^32, using the operand values held in that cycle.
- R7: Index 2 cannot be written. It changes only at the load in R6.
- R8: Writing control bit 0 as 0 clears status bit 0 at that same write edge.
- R9: Writing control bit 0 as 1 while it is already 1 starts no new addition. The result and the done flag keep their values even if the operands have changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe |
| addr | input | 16 | Byte address: segment, index and lane bits |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |

## Verification
On every cycle, the assertions check the following:
- a miss keeps `rdata` at zero;
- the result register moves only on a start event;
- a start event yields the operand sum and the done flag one clock later;
- a zero write clears the done flag;
- the done flag never stands without the control bit.

Some behaviour is visible only in the bench's scenarios, because it shows up only through port-level sequences:
- the exact readback words of the shared register;
- the dropping of the written status half;
- the no-restart rule for repeated starts;
- the carry wrap seen on random operands.

// File: rtl/adder_rb_pkg.sv
package adder_rb_pkg;
  typedef enum logic [1:0] {
    IDX_OPA = 2'd0,
    IDX_OPB = 2'd1,
    IDX_SUM = 2'd2,
    IDX_CSR = 2'd3
  } reg_idx_e;

  localparam int unsigned NUM_REGS    = 4;
  localparam int unsigned CTL_GO_BIT  = 0;
  localparam int unsigned STS_DN_BIT  = 0;
endpackage

// File: rtl/adder_rb_decode.sv
module adder_rb_decode #(
  parameter int unsigned SEG_W  = 12,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned LANE_W = 2,
  parameter logic [SEG_W-1:0] SEG_ID = 12'h321,
  localparam int unsigned ADDR_W = SEG_W + IDX_W + LANE_W,
  localparam int unsigned NSEL   = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              seg_hit,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  idx,
  output logic [NSEL-1:0]   wr_sel
);
  logic [SEG_W-1:0] seg_f;
  logic [LANE_W-1:0] lane_f;

  assign seg_f   = addr[ADDR_W-1 -: SEG_W];
  assign idx     = addr[LANE_W +: IDX_W];
  assign lane_f  = addr[LANE_W-1:0];
  assign seg_hit = (seg_f == SEG_ID) && (lane_f == '0);
  assign rd_hit  = seg_hit && rd_en;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign wr_sel[g] = seg_hit && wr_en && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/adder_rb_ctl.sv
module adder_rb_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic csr_wr,
  input  logic go_wbit,
  output logic ctl_go,
  output logic done,
  output logic start_evt,
  output logic clr_evt,
  output logic go_q
);
  // a start is a 0-to-1 move of the control bit; a zero write clears
  assign start_evt = csr_wr && go_wbit && !ctl_go;
  assign clr_evt   = csr_wr && !go_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_go <= 1'b0;
      go_q   <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (csr_wr) ctl_go <= go_wbit;
      go_q <= start_evt;
      if (clr_evt)   done <= 1'b0;
      else if (go_q) done <= 1'b1;
    end
  end
endmodule

// File: rtl/adder_rb_sum.sv
module adder_rb_sum #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  output logic [DW-1:0] opa,
  output logic [DW-1:0] opb,
  output logic [DW-1:0] sum
);
  function automatic logic [DW-1:0] mod_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa <= '0;
      opb <= '0;
      sum <= '0;
    end else begin
      if (wr_a) opa <= wdata;
      if (wr_b) opb <= wdata;
      if (load) sum <= mod_add(opa, opb);
    end
  end
endmodule

// File: rtl/adder_regblock.sv
module adder_regblock #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEG_W  = 12,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned LANE_W = 2,
  parameter logic [SEG_W-1:0] SEG_ID = 12'h321,
  localparam int unsigned ADDR_W = SEG_W + IDX_W + LANE_W,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned NSEL   = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import adder_rb_pkg::*;

  logic              seg_hit, rd_hit;
  logic [IDX_W-1:0]  idx;
  logic [NSEL-1:0]   wr_sel;
  logic              ctl_go, done, start_evt, clr_evt, go_q;
  logic [DATA_W-1:0] opa, opb, sum;
  logic [DATA_W-1:0] csr_word;
  logic              go_wbit;

  adder_rb_decode #(
    .SEG_W(SEG_W), .IDX_W(IDX_W), .LANE_W(LANE_W), .SEG_ID(SEG_ID)
  ) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .seg_hit(seg_hit), .rd_hit(rd_hit), .idx(idx), .wr_sel(wr_sel)
  );

  assign go_wbit = wdata[CTL_GO_BIT];

  adder_rb_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .csr_wr(wr_sel[IDX_CSR]), .go_wbit(go_wbit),
    .ctl_go(ctl_go), .done(done), .start_evt(start_evt),
    .clr_evt(clr_evt), .go_q(go_q)
  );

  adder_rb_sum #(.DW(DATA_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .wr_a(wr_sel[IDX_OPA]), .wr_b(wr_sel[IDX_OPB]),
    .wdata(wdata), .load(go_q), .opa(opa), .opb(opb), .sum(sum)
  );

  always_comb begin
    csr_word = '0;
    csr_word[HALF_W + STS_DN_BIT] = done;
    csr_word[CTL_GO_BIT]          = ctl_go;
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (idx)
        IDX_OPA: rdata = opa;
        IDX_OPB: rdata = opb;
        IDX_SUM: rdata = sum;
        default: rdata = csr_word;
      endcase
    end
  end
endmodule

// File: rtl/adder_regblock_chk.sv
module adder_regblock_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          seg_hit,
  input logic [DW-1:0] rdata,
  input logic          start_evt,
  input logic          go_q,
  input logic          clr_evt,
  input logic          ctl_go,
  input logic          done,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic [DW-1:0] sum
);
  logic [DW-1:0] ab_sum;
  assign ab_sum = opa + opb;

  assert_miss_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || !seg_hit) |-> (rdata == '0));

  assert_start_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> go_q);

  assert_sum_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> (sum == $past(ab_sum)));

  assert_done_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !clr_evt) |=> done);

  assert_sum_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !go_q |=> $stable(sum));

  assert_clear_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !done);

  assert_done_needs_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctl_go);
endmodule

bind adder_regblock adder_regblock_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .seg_hit(seg_hit), .rdata(rdata),
  .start_evt(start_evt), .go_q(go_q), .clr_evt(clr_evt), .ctl_go(ctl_go),
  .done(done), .opa(opa), .opb(opb), .sum(sum)
);

// File: tb/adder_regblock_tb_top.sv
module adder_regblock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adder_regblock dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  localparam logic [11:0] SEG = 12'h321;

  function automatic logic [31:0] exp_sum(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic c;
    c = 1'b0;
    for (int i = 0; i < 32; i++) begin
      r[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return r;
  endfunction

  function automatic logic [15:0] mk_addr(input logic [11:0] s, input logic [1:0] i);
    return {s, i, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, xa, xb, zk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      bus_rd(mk_addr(SEG, 2'(i)), v);
      check("R3 reset", v, 32'h0);
    end

    bus_wr(mk_addr(SEG, 2'd0), 32'hAA55A5A5);
    bus_wr(mk_addr(SEG, 2'd1), 32'h11221212);
    bus_rd(mk_addr(SEG, 2'd0), v); check("R2 opA", v, 32'hAA55A5A5);
    bus_rd(mk_addr(SEG, 2'd1), v); check("R2 opB", v, 32'h11221212);

    // start with junk in status half and upper control bits
    bus_wr(mk_addr(SEG, 2'd3), 32'hFFFF_FFFF);
    bus_rd(mk_addr(SEG, 2'd3), v); check("R5 not yet done", v, 32'h0000_0001);
    bus_rd(mk_addr(SEG, 2'd3), v); check("R4 R5 csr", v, 32'h0001_0001);
    bus_rd(mk_addr(SEG, 2'd2), v); check("R6 sum", v, 32'hBB77B7B7);

    bus_wr(mk_addr(SEG, 2'd2), 32'h1234_5678);
    bus_rd(mk_addr(SEG, 2'd2), v); check("R7 readonly", v, 32'hBB77B7B7);

    bus_wr(mk_addr(SEG, 2'd0), 32'h0000_0001);
    bus_wr(mk_addr(SEG, 2'd3), 32'h0000_0001);
    idle();
    bus_rd(mk_addr(SEG, 2'd2), v); check("R9 no restart sum", v, 32'hBB77B7B7);
    bus_rd(mk_addr(SEG, 2'd3), v); check("R9 csr", v, 32'h0001_0001);

    bus_wr(mk_addr(SEG, 2'd3), 32'hFFFF_0000);
    bus_rd(mk_addr(SEG, 2'd3), v); check("R8 clear", v, 32'h0);

    bus_wr(mk_addr(12'h320, 2'd0), 32'hDEAD_BEEF);
    bus_wr(mk_addr(SEG, 2'd0) | 16'h1, 32'hDEAD_BEEF);
    bus_rd(mk_addr(SEG, 2'd0), v); check("R1 miss write", v, 32'h0000_0001);
    bus_rd(mk_addr(12'h123, 2'd0), v); check("R1 miss read", v, 32'h0);
    addr = mk_addr(SEG, 2'd0); rd_en = 1'b0;
    #1 check("R1 no rd_en", rdata, 32'h0);

    // carry wrap corner
    bus_wr(mk_addr(SEG, 2'd0), 32'hFFFF_FFFF);
    bus_wr(mk_addr(SEG, 2'd1), 32'h0000_0002);
    bus_wr(mk_addr(SEG, 2'd3), 32'h1);
    idle();
    bus_rd(mk_addr(SEG, 2'd2), v); check("R6 wrap", v, 32'h0000_0001);

    void'($urandom(32'd2024));
    for (int k = 0; k < 40; k++) begin
      xa = $urandom; xb = $urandom;
      bus_wr(mk_addr(SEG, 2'd0), xa);
      bus_wr(mk_addr(SEG, 2'd1), xb);
      bus_wr(mk_addr($urandom_range(0, 1) ? 12'h321 : 12'h0F0, 2'd2), $urandom);
      bus_wr(mk_addr(SEG, 2'd3), {16'($urandom), 16'h0000});
      bus_rd(mk_addr(SEG, 2'd3), v); check("R8 rand clear", v, 32'h0);
      bus_wr(mk_addr(SEG, 2'd3), {16'($urandom), 15'($urandom), 1'b1});
      idle();
      zk = exp_sum(xa, xb);
      bus_rd(mk_addr(SEG, 2'd2), v); check("R6 rand sum", v, zk);
      bus_rd(mk_addr(SEG, 2'd3), v); check("R4 rand csr", v, 32'h0001_0001);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule